// File: doc/BRIEF.md
# Block-Counted SPI Master with Word FIFOs

This block is a serial-peripheral master controlled through a small 32-bit register window. Software writes a command word that selects word length, clock idle level, data edge, transfer directions and chip-select behaviour. It loads up to four data words into a transmit FIFO, then writes a block-control word. That word carries the number of words to move, the per-direction completion interrupt enables and a start bit.

The controller then runs the block by itself. For each word it takes one entry from the transmit FIFO, shifts it out most significant bit first on `mosi`, and collects the same number of bits from `miso` into the receive FIFO. The selected chip select is held active for the whole block. At the end the start bit drops, a ready flag is set and, if enabled, the interrupt line rises. Status flags for done, transmit overflow and receive underflow are cleared by writing one to them. Writing one to either of two other status bits empties a FIFO.

The serial clock is the system clock divided by the fixed even parameter `CLK_DIV`.

Top module: `spi_word_master`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x0280_0000 (receive-empty bit 25 and transmit-empty bit 23 set, everything else clear), all four `cs_pins` are high, `sclk` is low and `irq` is low.
- R2: Command bits 4:0 hold the word length minus one (1 to 32 bits). Each word gives exactly that many `sclk` pulses, and `mosi` carries bit (length-1) first, down to bit 0.
- R3: Command bit 26 sets the idle level of `sclk`. With command bit 21 clear, `miso` is sampled on the first (leading) edge of each pulse. With it set, `miso` is sampled on the second edge. Each received word is stored right-aligned in the receive FIFO, which is read at offset 0x20.
- R4: Block-control (offset 0x0C) bits 15:0 hold the word count minus one, and bit 31 starts the block. Exactly that many words are moved and unused transmit entries stay queued. While the block runs, status bit 31 (busy) reads 1. At the end, block-control bit 31 reads 0 and status bit 30 (ready) is set.
- R5: With command bit 15 (transmit enable) clear, `mosi` stays 0 for the whole block. With command bit 14 (receive enable) clear, nothing is written into the receive FIFO.
- R6: A write to the transmit FIFO (offset 0x10) while it holds four words sets status bit 26 (overflow), and the word is dropped. Status bit 22 shows the full state.
- R7: A read of the receive FIFO while it is empty sets status bit 27 (underflow) and returns 0.
- R8: Writing 1 to status bits 30, 27 or 26 clears that bit. Writing 0 leaves it unchanged.
- R9: Writing 1 to status bit 29 empties the transmit FIFO, and writing 1 to bit 28 empties the receive FIFO.
- R10: `irq` is high exactly while ready is set and either block-control bit 26 and transmit enable are both set, or block-control bit 27 and receive enable are both set.
- R11: Command bits 8:5 select chip selects 0 to 3, which are active low unless command bit 16 is set. With command bit 12 clear, the selected lines are active from block start until after the last word and are released when the block ends. With bit 12 set, the selected lines follow command bit 13 (1 = active) regardless of any block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x20) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pins | output | 4 | Chip-select lines |
| irq | output | 1 | Block-complete interrupt, level |

## Verification
The assertions assume that software does not rewrite the command register while a block is running. The idle-clock, chip-select and zero-output properties compare against the live command bits. The stimulus therefore writes the command word only while busy reads 0, and it polls busy before every reconfiguration. The bench also never asserts read and write in the same cycle. It attaches a loopback slave that ties `miso` to `mosi` and records `mosi` on the sampling edge the current mode defines, so the transmitted and received words can both be compared with the table.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    localparam logic [7:0] ADDR_CMD  = 8'h00;
    localparam logic [7:0] ADDR_STAT = 8'h04;
    localparam logic [7:0] ADDR_BCTL = 8'h0C;
    localparam logic [7:0] ADDR_TXQ  = 8'h10;
    localparam logic [7:0] ADDR_RXQ  = 8'h20;

    localparam int NUM_CS = 4;

    // command word bit positions
    localparam int C_CPOL   = 26;
    localparam int C_CPHA   = 21;
    localparam int C_CSINV  = 16;
    localparam int C_TXEN   = 15;
    localparam int C_RXEN   = 14;
    localparam int C_CSLVL  = 13;
    localparam int C_CSSW   = 12;
    localparam int C_CSLO   = 5;

    // status word bit positions
    localparam int S_BUSY   = 31;
    localparam int S_RDY    = 30;
    localparam int S_TXFL   = 29;
    localparam int S_RXFL   = 28;
    localparam int S_UNF    = 27;
    localparam int S_OVF    = 26;

    // block-control bit positions
    localparam int B_GO     = 31;
    localparam int B_RXIE   = 27;
    localparam int B_TXIE   = 26;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [4:0] len_m1;
        logic       tx_en;
        logic       rx_en;
    } shift_cfg_t;

    typedef struct packed {
        logic        go;
        logic        rx_ie;
        logic        tx_ie;
        logic [15:0] cnt_m1;
    } blk_ctl_t;

    typedef struct packed {
        logic              sw;
        logic              lvl;
        logic              inv;
        logic [NUM_CS-1:0] sel;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_LOAD  = 2'd1,
        E_SHIFT = 2'd2,
        E_TAIL  = 2'd3
    } eng_state_e;

    function automatic shift_cfg_t cfg_from_cmd(input logic [31:0] c);
        shift_cfg_t r;
        r.cpol   = c[C_CPOL];
        r.cpha   = c[C_CPHA];
        r.len_m1 = c[4:0];
        r.tx_en  = c[C_TXEN];
        r.rx_en  = c[C_RXEN];
        return r;
    endfunction

    function automatic cs_cfg_t cs_from_cmd(input logic [31:0] c);
        cs_cfg_t r;
        r.sw  = c[C_CSSW];
        r.lvl = c[C_CSLVL];
        r.inv = c[C_CSINV];
        r.sel = c[C_CSLO +: NUM_CS];
        return r;
    endfunction

endpackage

// File: rtl/spiw_fifo.sv
module spiw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
    import spiw_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  shift_cfg_t  cfg_in,
    input  logic [15:0] cnt_m1,
    input  logic [31:0] tx_word,
    input  logic        tx_empty,
    input  logic        miso,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [31:0] rx_word,
    output logic        active,
    output logic        done,
    output logic        phase,
    output logic        mosi
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HCW-1:0] HC_TOP = HCW'(HALF - 1);

    eng_state_e  st;
    shift_cfg_t  cfg;
    logic [HCW-1:0] hc;
    logic [5:0]  eidx;
    logic [15:0] left;
    logic [31:0] tsr, rsr, load_word, aligned;
    logic        obit;
    logic        half_hit, fire, lead, smp, last;

    assign half_hit  = (hc == '0);
    assign fire      = (st == E_SHIFT) && half_hit;
    assign lead      = ~eidx[0];
    assign smp       = lead ^ cfg.cpha;
    assign last      = (eidx == {cfg.len_m1, 1'b1});
    assign tx_pop    = (st == E_LOAD) && cfg.tx_en && !tx_empty;
    assign load_word = (cfg.tx_en && !tx_empty) ? tx_word : 32'd0;
    assign aligned   = load_word << (5'd31 - cfg.len_m1);
    assign rx_word   = cfg.cpha ? {rsr[30:0], miso} : rsr;
    assign rx_push   = fire && last && cfg.rx_en;
    assign done      = (st == E_TAIL) && half_hit;
    assign active    = (st != E_IDLE);
    assign mosi      = obit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= E_IDLE;
            cfg   <= '0;
            hc    <= HC_TOP;
            eidx  <= '0;
            left  <= '0;
            tsr   <= '0;
            rsr   <= '0;
            obit  <= 1'b0;
            phase <= 1'b0;
        end else begin
            case (st)
                E_IDLE: begin
                    phase <= 1'b0;
                    if (start) begin
                        cfg  <= cfg_in;
                        left <= cnt_m1;
                        st   <= E_LOAD;
                    end
                end
                E_LOAD: begin
                    rsr  <= '0;
                    eidx <= '0;
                    hc   <= HC_TOP;
                    st   <= E_SHIFT;
                    if (!cfg.cpha) begin
                        obit <= aligned[31];
                        tsr  <= aligned << 1;
                    end else begin
                        tsr  <= aligned;
                    end
                end
                E_SHIFT: begin
                    if (!half_hit) begin
                        hc <= hc - 1'b1;
                    end else begin
                        hc    <= HC_TOP;
                        phase <= ~phase;
                        eidx  <= eidx + 1'b1;
                        if (smp) begin
                            rsr <= {rsr[30:0], miso};
                        end else begin
                            obit <= tsr[31];
                            tsr  <= tsr << 1;
                        end
                        if (last) begin
                            if (left == '0) begin
                                st <= E_TAIL;
                            end else begin
                                left <= left - 1'b1;
                                st   <= E_LOAD;
                            end
                        end
                    end
                end
                E_TAIL: begin
                    if (!half_hit) begin
                        hc <= hc - 1'b1;
                    end else begin
                        obit <= 1'b0;
                        st   <= E_IDLE;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spiw_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_pins,
    output logic        irq
);
    logic [31:0] cmd_q;
    blk_ctl_t    bctl_q;
    logic        rdy_q, ovf_q, unf_q;

    shift_cfg_t  cfg_now;
    cs_cfg_t     csc;

    logic        wr_cmd, wr_stat, wr_bctl, wr_txq, rd_rxq;
    logic        tx_flush, rx_flush;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic [31:0] tx_head, rx_head, rx_word;
    logic        tx_pop, rx_push;
    logic        eng_active, eng_done, eng_phase, start;
    logic [NUM_CS-1:0] cs_act;

    assign cfg_now  = cfg_from_cmd(cmd_q);
    assign csc      = cs_from_cmd(cmd_q);

    assign wr_cmd   = bus_wr && (bus_addr == ADDR_CMD);
    assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_bctl  = bus_wr && (bus_addr == ADDR_BCTL);
    assign wr_txq   = bus_wr && (bus_addr == ADDR_TXQ);
    assign rd_rxq   = bus_rd && (bus_addr == ADDR_RXQ);
    assign tx_flush = wr_stat && bus_wdata[S_TXFL];
    assign rx_flush = wr_stat && bus_wdata[S_RXFL];
    assign start    = wr_bctl && bus_wdata[B_GO] && !eng_active && !bctl_q.go;

    spiw_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_txq), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spiw_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .din(rx_word),
        .pop(rd_rxq), .dout(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    spiw_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst), .start(start),
        .cfg_in(cfg_now), .cnt_m1(bus_wdata[15:0]),
        .tx_word(tx_head), .tx_empty(tx_empty), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .active(eng_active), .done(eng_done),
        .phase(eng_phase), .mosi(mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            bctl_q <= '0;
            rdy_q  <= 1'b0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= bus_wdata;
            if (wr_bctl && !eng_active && !bctl_q.go) begin
                bctl_q.go     <= bus_wdata[B_GO];
                bctl_q.rx_ie  <= bus_wdata[B_RXIE];
                bctl_q.tx_ie  <= bus_wdata[B_TXIE];
                bctl_q.cnt_m1 <= bus_wdata[15:0];
            end else if (eng_done) begin
                bctl_q.go <= 1'b0;
            end
            if (eng_done)
                rdy_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_RDY])
                rdy_q <= 1'b0;
            if (wr_txq && tx_full)
                ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_OVF])
                ovf_q <= 1'b0;
            if (rd_rxq && rx_empty)
                unf_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_UNF])
                unf_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CMD:  bus_rdata = cmd_q;
            ADDR_STAT: bus_rdata = {eng_active, rdy_q, 2'b00, unf_q, ovf_q,
                                    rx_empty, rx_full, tx_empty, tx_full, 22'd0};
            ADDR_BCTL: bus_rdata = {bctl_q.go, 3'b000, bctl_q.rx_ie, bctl_q.tx_ie,
                                    10'd0, bctl_q.cnt_m1};
            ADDR_RXQ:  bus_rdata = rx_empty ? 32'd0 : rx_head;
            default:   bus_rdata = 32'd0;
        endcase
    end

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign cs_act[i]  = csc.sel[i] && (csc.sw ? csc.lvl : eng_active);
            assign cs_pins[i] = csc.inv ? cs_act[i] : ~cs_act[i];
        end
    endgenerate

    assign sclk = eng_phase ^ cfg_now.cpol;
    assign irq  = rdy_q && ((bctl_q.tx_ie && cfg_now.tx_en) ||
                            (bctl_q.rx_ie && cfg_now.rx_en));
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       ready,
    input logic       irq,
    input logic       sclk,
    input logic       mosi,
    input logic [31:0] cmd,
    input logic [3:0] cs_pins,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic       tx_full,
    input logic       rx_empty,
    input logic       ovf,
    input logic       unf
);
    assert_idle_clock_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cmd[26]));

    assert_block_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ready);

    assert_quiet_out_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd[15]) |-> !mosi);

    assert_tx_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h10 && tx_full) |=> ovf);

    assert_rx_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h20 && rx_empty) |=> unf);

    assert_irq_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ready);

    assert_hw_select_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd[12] && cmd[5]) |-> (cs_pins[0] == cmd[16]));
endmodule

bind spi_word_master spiw_checker u_chk (
    .clk(clk), .rst(rst), .busy(eng_active), .ready(rdy_q), .irq(irq),
    .sclk(sclk), .mosi(mosi), .cmd(cmd_q), .cs_pins(cs_pins),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .tx_full(tx_full), .rx_empty(rx_empty), .ovf(ovf_q), .unf(unf_q)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_pins;
    logic        irq;

    int total = 0, bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_word_master u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pins(cs_pins), .irq(irq)
    );

    // loopback slave: echoes mosi, records mosi on the mode's sampling edge
    assign miso = mosi;
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, slv_on = 1'b0;
    logic [63:0] cap = '0;
    int          pulses = 0;

    always @(sclk) begin
        if (slv_on && !rst && sclk !== 1'bx) begin
            if (sclk != cur_cpol) pulses++;
            if ((sclk != cur_cpol) ^ cur_cpha) cap = {cap[62:0], mosi};
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            bad++; total++;
            $display("FAIL R4 watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'h8000_0000;
        while (s[31]) peek(8'h04, s);
    endtask

    function automatic logic [31:0] msk(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
    endfunction

    function automatic logic [31:0] mkcmd(input logic cpol, input logic cpha,
                                          input logic [4:0] lm1, input logic txe, input logic rxe);
        return (32'd1 << 28) | (32'(cpol) << 26) | (32'(cpha) << 21) |
               (32'(txe) << 15) | (32'(rxe) << 14) | (32'd1 << 5) | 32'(lm1);
    endfunction

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [4:0]  lm1;
        logic [31:0] w0;
        logic [31:0] w1;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{1'b0, 1'b0, 5'd7,  32'h0000_00A5, 32'h0000_003C},
        '{1'b0, 1'b1, 5'd15, 32'h0000_BEEF, 32'h0000_1234},
        '{1'b1, 1'b0, 5'd31, 32'hDEAD_BEEF, 32'h8000_0001},
        '{1'b1, 1'b1, 5'd7,  32'h0000_0081, 32'hFFFF_FF7E},
        '{1'b0, 1'b0, 5'd0,  32'h0000_0001, 32'h0000_0000},
        '{1'b1, 1'b1, 5'd15, 32'hABCD_5A5A, 32'h0000_C003}
    };

    initial begin
        logic [31:0] d;
        logic [63:0] expc;
        int len;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(8'h04, d);
        check("R1 status", 64'(d), 64'h0280_0000);
        check("R1 cs", 64'(cs_pins), 64'hF);
        check("R1 sclk", 64'(sclk), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // table of mode/length vectors, two words each
        foreach (VT[i]) begin
            len = int'(VT[i].lm1) + 1;
            wr(8'h00, mkcmd(VT[i].cpol, VT[i].cpha, VT[i].lm1, 1'b1, 1'b1));
            cur_cpol = VT[i].cpol; cur_cpha = VT[i].cpha;
            @(negedge clk);
            check("R3 idle sclk", 64'(sclk), 64'(VT[i].cpol));
            wr(8'h10, VT[i].w0);
            wr(8'h10, VT[i].w1);
            cap = '0; pulses = 0; slv_on = 1'b1;
            wr(8'h0C, 32'h8000_0001);
            repeat (2) @(negedge clk);
            peek(8'h04, d);
            check("R4 busy during block", 64'(d[31]), 64'h1);
            check("R11 cs held", 64'(cs_pins), 64'hE);
            wait_idle();
            slv_on = 1'b0;
            check("R2 pulse count", 64'(pulses), 64'(2 * len));
            expc = (64'(VT[i].w0 & msk(len)) << len) | 64'(VT[i].w1 & msk(len));
            check("R2 mosi order", cap & ((len == 32) ? 64'hFFFF_FFFF_FFFF_FFFF
                                          : ((64'd1 << (2 * len)) - 1)), expc);
            check("R11 cs released", 64'(cs_pins), 64'hF);
            peek(8'h0C, d);
            check("R4 go cleared", 64'(d[31]), 64'h0);
            peek(8'h04, d);
            check("R4 ready", 64'(d[30]), 64'h1);
            rd(8'h20, d);
            check("R3 rx word0", 64'(d), 64'(VT[i].w0 & msk(len)));
            rd(8'h20, d);
            check("R3 rx word1", 64'(d), 64'(VT[i].w1 & msk(len)));
            wr(8'h04, 32'h4000_0000);
        end

        // R4: count smaller than queued words, extra stays queued
        wr(8'h00, mkcmd(1'b0, 1'b0, 5'd7, 1'b1, 1'b1));
        cur_cpol = 0; cur_cpha = 0;
        for (int k = 0; k < 3; k++) wr(8'h10, 32'h11 * (k + 1));
        pulses = 0; slv_on = 1'b1;
        wr(8'h0C, 32'h8000_0001);
        wait_idle();
        slv_on = 1'b0;
        check("R4 two words pulses", 64'(pulses), 64'd16);
        peek(8'h04, d);
        check("R4 tx entry left", 64'(d[23]), 64'h0);
        rd(8'h20, d); rd(8'h20, d);
        check("R4 second word", 64'(d), 64'h22);
        peek(8'h04, d);
        check("R4 rx drained", 64'(d[25]), 64'h1);

        // R9 flush of the leftover transmit entry
        wr(8'h04, 32'h2000_0000);
        peek(8'h04, d);
        check("R9 tx flush", 64'(d[23]), 64'h1);

        // R7 underflow and R8 write-1-to-clear
        rd(8'h20, d);
        check("R7 empty read data", 64'(d), 64'h0);
        peek(8'h04, d);
        check("R7 underflow", 64'(d[27]), 64'h1);
        wr(8'h04, 32'h0);
        peek(8'h04, d);
        check("R8 zero write keeps", 64'(d[27]), 64'h1);
        wr(8'h04, 32'h0800_0000);
        peek(8'h04, d);
        check("R8 unf cleared", 64'(d[27]), 64'h0);

        // R6 overflow
        for (int k = 0; k < 5; k++) wr(8'h10, 32'h100 + k);
        peek(8'h04, d);
        check("R6 overflow", 64'(d[26]), 64'h1);
        check("R6 full", 64'(d[22]), 64'h1);
        wr(8'h04, 32'h0400_0000);
        peek(8'h04, d);
        check("R8 ovf cleared", 64'(d[26]), 64'h0);
        // run 4 words and confirm the dropped fifth never appears
        pulses = 0; slv_on = 1'b1;
        wr(8'h0C, 32'h8000_0003);
        wait_idle();
        slv_on = 1'b0;
        check("R4 four words pulses", 64'(pulses), 64'd32);
        for (int k = 0; k < 4; k++) begin
            rd(8'h20, d);
            check("R6 kept words", 64'(d), 64'(8'h00 + k));
        end
        peek(8'h04, d);
        check("R6 fifth dropped", 64'(d[25]), 64'h1);
        wr(8'h04, 32'h4000_0000);

        // R5 transmit disabled: zeros out, zeros in
        wr(8'h00, mkcmd(1'b0, 1'b1, 5'd7, 1'b0, 1'b1));
        cur_cpha = 1;
        wr(8'h10, 32'hFF);
        cap = '1; pulses = 0; slv_on = 1'b1;
        wr(8'h0C, 32'h8000_0000);
        wait_idle();
        slv_on = 1'b0;
        check("R5 mosi zero", cap & 64'hFF, 64'h0);
        rd(8'h20, d);
        check("R5 rx zero", 64'(d), 64'h0);
        wr(8'h04, 32'h6000_0000);

        // R5 receive disabled: nothing stored; R10 irq via tx enable
        wr(8'h00, mkcmd(1'b0, 1'b0, 5'd7, 1'b1, 1'b0));
        cur_cpha = 0;
        wr(8'h10, 32'h5A);
        wr(8'h0C, 32'h8400_0000);
        wait_idle();
        peek(8'h04, d);
        check("R5 rx stays empty", 64'(d[25]), 64'h1);
        check("R10 irq tx", 64'(irq), 64'h1);
        wr(8'h04, 32'h4000_0000);
        @(negedge clk);
        check("R10 irq clears", 64'(irq), 64'h0);

        // R10 receive interrupt enable with receive off gives no irq
        wr(8'h10, 32'h5A);
        wr(8'h0C, 32'h8800_0000);
        wait_idle();
        peek(8'h04, d);
        check("R10 ready set", 64'(d[30]), 64'h1);
        check("R10 no irq", 64'(irq), 64'h0);
        wr(8'h04, 32'h4000_0000);

        // R11 software control, level and polarity, hardware inverted
        wr(8'h00, (32'd1 << 12) | (32'd1 << 13) | (32'd1 << 7));
        @(negedge clk);
        check("R11 sw active low", 64'(cs_pins), 64'hB);
        wr(8'h00, (32'd1 << 16) | (32'd1 << 12) | (32'd1 << 13) | (32'd1 << 7));
        @(negedge clk);
        check("R11 sw inverted", 64'(cs_pins), 64'h4);
        wr(8'h00, (32'd1 << 16) | (32'd1 << 12) | (32'd1 << 7));
        @(negedge clk);
        check("R11 sw level low", 64'(cs_pins), 64'h0);
        wr(8'h00, (32'd1 << 16) | (32'd1 << 15) | (32'd1 << 6) | 32'd7);
        wr(8'h10, 32'h33);
        wr(8'h0C, 32'h8000_0000);
        repeat (3) @(negedge clk);
        check("R11 hw inverted held", 64'(cs_pins), 64'h2);
        wait_idle();
        check("R11 hw inverted released", 64'(cs_pins), 64'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule